// File: doc/BRIEF.md
# Strobe-Wait Read Servant

This block is the responding side of a single-word read transfer. A master raises `req_i` with an address on `addr_i`. The servant latches the address and starts a read on an internal memory port. That port answers with a ready pulse after a variable number of cycles.

When the memory answers inside a fixed access window of `ACCESS_CYC` clock cycles, the servant places the word on `data_o` and leaves `wait_o` low. This is the strobe-style fast path: the master may sample the data as soon as the window has run out. When the window runs out first, the servant raises `wait_o` and keeps it high until the word arrives. It then presents the word and drops `wait_o` in the same cycle. The master takes the data and releases `req_i`. The servant accepts the next request only after it has seen `req_i` low.

The controller is built around one state machine with four states:
- `SW_IDLE`: armed, waiting for a request.
- `SW_FETCH`: the read is in flight and the access window is still open.
- `SW_STALL`: the read is in flight, the window has expired and `wait_o` is high.
- `SW_PRESENT`: the word is on the bus and the servant waits for `req_i` to fall.

Its transitions are:
- start: `SW_IDLE` to `SW_FETCH` on `req_i`.
- fast hit: `SW_FETCH` to `SW_PRESENT` on memory ready.
- timeout: `SW_FETCH` to `SW_STALL` when the window's last cycle passes without ready.
- late hit: `SW_STALL` to `SW_PRESENT` on memory ready.
- release: `SW_PRESENT` to `SW_IDLE` when `req_i` is low.

Top module: `strobe_wait_servant`

## Requirements
- R1: After reset, `wait_o` and `mem_rd_o` are low.
- R2: A request sampled in the idle state makes `mem_rd_o` high from the next cycle on, with `mem_addr_o` equal to the address sampled with the request.
- R3: Let j count clock edges after the edge that sampled the request (j = 0 at that edge), and let L be the number of cycles the memory needs after `mem_rd_o` rises. If L < `ACCESS_CYC`, `wait_o` never rises during the transfer, and the word appears on `data_o` after edge j = L+1.
- R4: If L >= `ACCESS_CYC`, `wait_o` goes high after edge j = `ACCESS_CYC` and stays high through edge j = L.
- R5: On the slow path, `wait_o` falls after edge j = L+1, in the same cycle that the valid word appears on `data_o`.
- R6: While `req_i` stays high after the word has been presented, `data_o` does not change.
- R7: While `req_i` stays high after the word has been presented, no new memory read starts. One cycle with `req_i` low re-arms the servant.
- R8: `mem_rd_o` stays high, and `mem_addr_o` stays unchanged, until the cycle in which the memory answers. After that cycle `mem_rd_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request from the master |
| addr_i | input | ADDR_W | Read address, sampled with the request |
| data_o | output | DATA_W | Read word presented to the master |
| wait_o | output | 1 | High while the servant is late beyond the access window |
| mem_rd_o | output | 1 | Internal memory read strobe |
| mem_addr_o | output | ADDR_W | Latched address to the internal memory |
| mem_ready_i | input | 1 | Memory answers in this cycle |
| mem_data_i | input | DATA_W | Memory word, valid with `mem_ready_i` |

## Verification
The bench sweeps the memory latency from zero up to several cycles past the access window. Latencies below `ACCESS_CYC` must take the fast path. Latencies at or above it must raise `wait_o`, and that edge is checked cycle by cycle against the exact window boundary.

For every latency, the bench also varies two things: how long the master keeps `req_i` high after the data, and the address. Holding `req_i` high tells a servant that re-triggers apart from one that truly waits for release. Each transfer returns a different word, so data shown a cycle early or a cycle late is caught.

// File: rtl/sw_pkg.sv
package sw_pkg;
    typedef enum logic [1:0] {
        SW_IDLE    = 2'd0,
        SW_FETCH   = 2'd1,
        SW_STALL   = 2'd2,
        SW_PRESENT = 2'd3
    } sw_state_e;
endpackage

// File: rtl/sw_access_timer.sv
module sw_access_timer #(
    parameter int ACCESS_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int CNT_W = (ACCESS_CYC > 1) ? $clog2(ACCESS_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ACCESS_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // High in the final cycle of the access window.
    assign last_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sw_word_hold.sv
module sw_word_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/strobe_wait_servant.sv
module strobe_wait_servant #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int ACCESS_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              wait_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_ready_i,
    input  logic [DATA_W-1:0] mem_data_i
);
    import sw_pkg::*;

    sw_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              window_last;
    logic              word_load;

    // Access window timer, runs only while the fetch is inside the window.
    sw_access_timer #(.ACCESS_CYC(ACCESS_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == SW_FETCH),
        .last_o (window_last)
    );

    sw_word_hold #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (word_load),
        .d_i    (mem_data_i),
        .q_o    (data_o)
    );

    // State register and address latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SW_IDLE && req_i) begin
                addr_q <= addr_i;
            end
        end
    end

    // Transitions: start, fast hit, timeout, late hit, release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE:    if (req_i)            state_d = SW_FETCH;
            SW_FETCH:   if (mem_ready_i)      state_d = SW_PRESENT;
                        else if (window_last) state_d = SW_STALL;
            SW_STALL:   if (mem_ready_i)      state_d = SW_PRESENT;
            SW_PRESENT: if (!req_i)           state_d = SW_IDLE;
            default:                          state_d = SW_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        mem_rd_o   = 1'b0;
        wait_o     = 1'b0;
        unique case (state_q)
            SW_IDLE:    ;
            SW_FETCH:   mem_rd_o = 1'b1;
            SW_STALL: begin
                mem_rd_o = 1'b1;
                wait_o   = 1'b1;
            end
            SW_PRESENT: ;
            default:    ;
        endcase
        mem_addr_o = addr_q;
        word_load  = mem_rd_o && mem_ready_i;
    end

    // Window expired without data: wait must follow.
    assert_timeout_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_FETCH && window_last && !mem_ready_i) |=> wait_o);

    // Answer inside the window: no wait in the next cycle.
    assert_fast_nowait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_FETCH && mem_ready_i) |=> !wait_o);

    // Wait only falls when the word is presented.
    assert_wait_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_o) |-> (state_q == SW_PRESENT && $past(mem_ready_i)));

    // The word is held while the master keeps the request.
    assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_PRESENT && req_i) |=> $stable(data_o));

    // No re-trigger without a low request.
    assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_PRESENT && req_i) |=> !mem_rd_o);

    // The read strobe and address hold until the memory answers.
    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_ready_i) |=> (mem_rd_o && $stable(mem_addr_o)));
endmodule

// File: tb/tb_strobe_wait_servant.sv
module tb_strobe_wait_servant;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int ACCESS_CYC = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] data;
    logic              wait_s;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ready;
    logic [DATA_W-1:0] mem_data;

    int tests = 0;
    int fails = 0;
    int lat   = 0;
    int txn   = 1;
    logic [3:0] rd_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_wait_servant #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACCESS_CYC(ACCESS_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr),
        .data_o(data), .wait_o(wait_s), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
        .mem_ready_i(mem_ready), .mem_data_i(mem_data)
    );

    // Memory model: answers after lat cycles of read strobe.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_cnt <= '0;
        else if (!mem_rd) rd_cnt <= '0;
        else             rd_cnt <= rd_cnt + 1'b1;
    end
    assign mem_ready = mem_rd && (int'(rd_cnt) == lat);
    assign mem_data  = {mem_addr, 8'(txn)};

    task automatic check(input bit ok, input string req_tag, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (lat %0d txn %0d)",
                     req_tag, what, act, exp, lat, txn);
        end
    endtask

    task automatic transfer(input int l, input logic [ADDR_W-1:0] a, input int hold);
        logic [DATA_W-1:0] exp_word;
        logic [DATA_W-1:0] shown;
        bit slow;
        lat = l;
        exp_word = {a, 8'(txn)};
        slow = (l >= ACCESS_CYC);
        req  = 1'b1;
        addr = a;
        for (int j = 0; j <= l + 1 + hold; j++) begin
            @(posedge clk);
            @(negedge clk);
            addr = ~a;
            if (j <= l) begin
                // R2 R8: strobe and address held during the read
                check(mem_rd == 1'b1, "R8", "mem_rd during read", mem_rd, 1);
                check(mem_addr == a, "R2", "mem_addr", mem_addr, a);
                check(data != exp_word, "R3", "data not early", data, exp_word);
                if (slow)
                    check(wait_s == (j >= ACCESS_CYC), "R4", "wait in slow read",
                          wait_s, (j >= ACCESS_CYC));
                else
                    check(wait_s == 1'b0, "R3", "no wait in fast read", wait_s, 0);
            end else if (j == l + 1) begin
                shown = data;
                check(data == exp_word, slow ? "R5" : "R3", "data presented", data, exp_word);
                check(wait_s == 1'b0, slow ? "R5" : "R3", "wait low with data", wait_s, 0);
                check(mem_rd == 1'b0, "R8", "mem_rd after answer", mem_rd, 0);
            end else begin
                check(data == shown, "R6", "data held", data, shown);
                check(mem_rd == 1'b0, "R7", "no new read while req high", mem_rd, 0);
                check(wait_s == 1'b0, "R7", "wait low while req high", wait_s, 0);
            end
        end
        req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(data == shown, "R6", "data after release", data, shown);
        check(mem_rd == 1'b0, "R7", "idle after release", mem_rd, 0);
        txn++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(wait_s == 1'b0, "R1", "wait in reset", wait_s, 0);
        check(mem_rd == 1'b0, "R1", "mem_rd in reset", mem_rd, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wait_s == 1'b0 && mem_rd == 1'b0, "R1", "idle after reset", {wait_s, mem_rd}, 0);
        for (int l = 0; l <= 6; l++) begin
            for (int h = 0; h <= 2; h++) begin
                transfer(l, 8'(8'h11 * (l + 1) + h * 8'h40), h);
            end
        end
        // R7: request raised again right after one low cycle must start a read
        transfer(0, 8'hA5, 0);
        transfer(ACCESS_CYC, 8'h5A, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule